// File: doc/BRIEF.md
# Self-Checking Coded Moore Machine

This block is a four-state Moore controller built so that its own faults become visible. Every value it handles carries redundancy. The input bit arrives on two complementary rails. The state register holds a 2-out-of-4 codeword. The output bit leaves on two complementary rails. The next-state and output networks are built only from AND and OR terms of true (uncomplemented) signals. A fault that forces lines one way therefore moves the state toward all-zero or toward extra ones. It cannot move the state onto another valid codeword.

A built-in checker continuously watches the input pair and the state register. It drives a two-rail status pair, `err`. A healthy status has exactly one bit set. A faulty status has both bits equal. Because the status is itself two-rail, a stuck status line also shows up as a fault. Once a corrupt value has entered the state register, the machine stays off the codeword set until reset. The fault indication therefore persists and is not lost.

Top module: `scfsm_coded_moore`

## Requirements
- R1: A synchronous active-high reset loads state A (code 0011, bit 3 first). With `rst` low and state A, `z` reads 10 and `err` is healthy.
- R2: The state codes are A=0011, B=0101, C=1010 and D=1001. The input pair `x` codes logic 0 as 01 and logic 1 as 10, with `x[1]` as the one-rail. On each rising clock edge the machine moves as follows. A goes to C on 0 and stays in A on 1. B goes to D on 0 and to C on 1. C goes to B on 0 and to D on 1. D goes to C on 0 and to A on 1.
- R3: The output depends only on the state. `z` is 10 (logic 1) in states A and B, and 01 (logic 0) in states C and D.
- R4: When `x` is 01 or 10 and the state is a valid codeword, `err` has exactly one bit set (healthy).
- R5: Whenever `x` is 00 or 11, `err` shows a faulty value (00 or 11) in the same cycle, without waiting for a clock edge.
- R6: A clock edge with `x` = 00 empties the state register to 0000. After that, `z` reads 00 and `err` stays faulty on every later cycle, for any input, until reset.
- R7: A clock edge with `x` = 11 loads a state with more than two bits set. From state A this makes `z` read 11. `err` then stays faulty on every later cycle, for any input, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to state A |
| x | input | 2 | Two-rail input bit: 01 = 0, 10 = 1 |
| z | output | 2 | Two-rail Moore output: 10 = 1, 01 = 0 |
| err | output | 2 | Two-rail status: 01/10 healthy, 00/11 faulty |

## Verification
A directed walk takes every one of the eight state/input arcs once. This separates a swapped destination from a wrong output code, because each arc leaves a distinct trace of outputs. Long random two-rail sequences are then checked against a reference table. Their run of outputs exposes any wrong arc that hides behind two states sharing an output value. Finally, the all-zero input pair and the double-one input pair are applied, from A and from C. These show that the status flags the bad input at once, and that the resulting non-codeword state stays flagged under valid inputs until reset.

// File: rtl/scfsm_pkg.sv
`timescale 1ns/1ps
package scfsm_pkg;

    localparam int CODE_W = 4;
    localparam int HALF_W = CODE_W / 2;
    localparam int NUM_ST = 4;
    localparam int NUM_ARC = 2 * NUM_ST;

    typedef logic [CODE_W-1:0] code_t;

    // Two-rail pair: hi is the one-rail, lo the zero-rail.
    typedef struct packed {
        logic hi;
        logic lo;
    } rail_t;

    localparam code_t ST_A = 4'b0011;
    localparam code_t ST_B = 4'b0101;
    localparam code_t ST_C = 4'b1010;
    localparam code_t ST_D = 4'b1001;
    localparam code_t RESET_CODE = ST_A;

    // State index k: 0=A 1=B 2=C 3=D
    localparam code_t STATE_CODE [NUM_ST] = '{ST_A, ST_B, ST_C, ST_D};

    // Arc 2k+0: state k with input 0; arc 2k+1: state k with input 1
    localparam code_t NEXT_CODE [NUM_ARC] =
        '{ST_C, ST_A, ST_D, ST_C, ST_B, ST_D, ST_C, ST_A};

    // Bit k set: state k drives output logic 1
    localparam logic [NUM_ST-1:0] OUT_HI_MASK = 4'b0011;

    // Monotonic threshold: at least k ones among the bits
    function automatic logic at_least(input code_t bits, input int k);
        return $countones(bits) >= k;
    endfunction

    // Two-rail combiner: valid only if both pairs are valid
    function automatic rail_t rail_merge(input rail_t a, input rail_t b);
        rail_t r;
        r.hi = (a.hi & b.hi) | (a.lo & b.lo);
        r.lo = (a.hi & b.lo) | (a.lo & b.hi);
        return r;
    endfunction

endpackage

// File: rtl/scfsm_next_logic.sv
`timescale 1ns/1ps
module scfsm_next_logic
    import scfsm_pkg::*;
(
    input  code_t cur,
    input  rail_t xin,
    output code_t nxt,
    output rail_t zout
);

    logic [NUM_ST-1:0]  in_st;
    logic [NUM_ARC-1:0] fire;

    // Each state is recognised by the AND of its two set bits only.
    for (genvar k = 0; k < NUM_ST; k++) begin : g_dec
        assign in_st[k] = &(cur | ~STATE_CODE[k]);
        assign fire[2*k]   = in_st[k] & xin.lo;
        assign fire[2*k+1] = in_st[k] & xin.hi;
    end

    // Next state is an OR of fired arcs, masked by constant targets.
    always_comb begin
        nxt = '0;
        for (int i = 0; i < NUM_ARC; i++) begin
            nxt = nxt | ({CODE_W{fire[i]}} & NEXT_CODE[i]);
        end
    end

    assign zout.hi = |(in_st &  OUT_HI_MASK);
    assign zout.lo = |(in_st & ~OUT_HI_MASK);

endmodule

// File: rtl/scfsm_code_check.sv
`timescale 1ns/1ps
module scfsm_code_check
    import scfsm_pkg::*;
(
    input  code_t st,
    input  rail_t xin,
    output rail_t status
);

    logic [HALF_W-1:0] upper, lower;
    logic [HALF_W:0]   even_t, odd_t;
    rail_t             st_pair;

    assign upper = st[CODE_W-1:HALF_W];
    assign lower = st[HALF_W-1:0];

    // m-of-2m checker: terms with i ones in upper, m-i in lower
    for (genvar i = 0; i <= HALF_W; i++) begin : g_term
        logic hit;
        assign hit = at_least({{(CODE_W-HALF_W){1'b0}}, upper}, i)
                   & at_least({{(CODE_W-HALF_W){1'b0}}, lower}, HALF_W - i);
        if ((i % 2) == 0) begin : g_even
            assign even_t[i] = hit;
            assign odd_t[i]  = 1'b0;
        end else begin : g_odd
            assign even_t[i] = 1'b0;
            assign odd_t[i]  = hit;
        end
    end

    assign st_pair.lo = |even_t;
    assign st_pair.hi = |odd_t;

    assign status = rail_merge(st_pair, xin);

endmodule

// File: rtl/scfsm_coded_moore.sv
`timescale 1ns/1ps
module scfsm_coded_moore
    import scfsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] x,
    output logic [1:0] z,
    output logic [1:0] err
);

    rail_t x_rail, z_rail, stat;
    code_t state_q, state_d;

    assign x_rail = x;

    scfsm_next_logic u_next (
        .cur  (state_q),
        .xin  (x_rail),
        .nxt  (state_d),
        .zout (z_rail)
    );

    scfsm_code_check u_check (
        .st     (state_q),
        .xin    (x_rail),
        .status (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= RESET_CODE;
        else     state_q <= state_d;
    end

    assign z   = z_rail;
    assign err = stat;

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (state_q == RESET_CODE));

    assert_codeword_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($onehot(x) && $countones(state_q) == 2) |=> ($countones(state_q) == 2));

    assert_output_rails_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_q) == 2) |-> $onehot(z));

    assert_status_healthy_R4: assert property (@(posedge clk) disable iff (rst)
        ($onehot(x) && $countones(state_q) == 2) |-> $onehot(err));

    assert_bad_input_flag_R5: assert property (@(posedge clk) disable iff (rst)
        !$onehot(x) |-> !$onehot(err));

    assert_zero_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == '0) |=> (state_q == '0));

    assert_noncode_flag_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(state_q) != 2) |-> !$onehot(err));

endmodule

// File: tb/scfsm_coded_moore_tb.sv
`timescale 1ns/1ps
module scfsm_coded_moore_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] x   = 2'b01;
    logic [1:0] z;
    logic [1:0] err;

    always #10 clk = ~clk;

    scfsm_coded_moore u_dut (
        .clk (clk),
        .rst (rst),
        .x   (x),
        .z   (z),
        .err (err)
    );

    typedef struct {
        logic       chk_z;
        logic [1:0] z_exp;
        logic       bad;
        string      tag;
    } exp_t;

    typedef enum {M_GOOD, M_ZERO, M_OVER} mkind_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [3:0] ms;
    mkind_t     mk;
    logic       over_chk;
    logic [1:0] over_z;

    // Reference transitions from the requirement table (R2)
    function automatic logic [3:0] succ(input logic [3:0] s, input logic b);
        case (s)
            4'b0011: return b ? 4'b0011 : 4'b1010;
            4'b0101: return b ? 4'b1010 : 4'b1001;
            4'b1010: return b ? 4'b1001 : 4'b0101;
            default: return b ? 4'b0011 : 4'b1010;
        endcase
    endfunction

    // Reference output coding (R3)
    function automatic logic [1:0] zof(input logic [3:0] s);
        return (s == 4'b0011 || s == 4'b0101) ? 2'b10 : 2'b01;
    endfunction

    task automatic step(input logic [1:0] xv, input string tag);
        exp_t e;
        x = xv;
        e.tag = tag;
        case (mk)
            M_GOOD: begin e.chk_z = 1'b1; e.z_exp = zof(ms); e.bad = (xv == 2'b00 || xv == 2'b11); end
            M_ZERO: begin e.chk_z = 1'b1; e.z_exp = 2'b00; e.bad = 1'b1; end
            default: begin e.chk_z = over_chk; e.z_exp = over_z; e.bad = 1'b1; end
        endcase
        sb.push_back(e);
        over_chk = 1'b0;
        if (xv == 2'b00) begin
            mk = M_ZERO;
        end else if (xv == 2'b11) begin
            if (mk == M_GOOD) begin
                if (ms == 4'b0011) begin over_chk = 1'b1; over_z = 2'b11; end
                mk = M_OVER;
            end
        end else if (mk == M_GOOD) begin
            ms = succ(ms, xv[1]);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        x = 2'b01;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ms = 4'b0011;
        mk = M_GOOD;
        over_chk = 1'b0;
        over_z = 2'b00;
    endtask

    // Monitor: compare each expectation mid-way through the low phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.bad ? (err[1] !== err[0]) : (err[1] === err[0])) begin
                    errors++;
                    $display("FAIL %s: err=%b expected %s", e.tag, err, e.bad ? "00/11" : "01/10");
                end
                if (e.chk_z) begin
                    checks++;
                    if (z !== e.z_exp) begin
                        errors++;
                        $display("FAIL %s: z=%b expected %b", e.tag, z, e.z_exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: run still active after 200000 cycles, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state A, output 10, healthy status
        step(2'b10, "R1");

        // R2/R3: directed walk over all eight arcs
        step(2'b10, "R2 A-1");
        step(2'b01, "R2 A-0");
        step(2'b01, "R2 C-0");
        step(2'b10, "R2 B-1");
        step(2'b10, "R2 C-1");
        step(2'b01, "R2 D-0");
        step(2'b01, "R2 C-0");
        step(2'b01, "R2 B-0");
        step(2'b10, "R2 D-1");
        step(2'b01, "R3");

        // R2/R3/R4: random two-rail walk
        for (int i = 0; i < 300; i++) begin
            step(($urandom_range(0, 1) == 1) ? 2'b10 : 2'b01, "R2/R3/R4");
        end

        // R5 then R6: empty input pair poisons to all-zero state
        step(2'b00, "R5");
        step(2'b01, "R6");
        step(2'b10, "R6");
        step(2'b11, "R6");
        step(2'b01, "R6");

        // R5 then R7: double-one input from A
        do_reset();
        step(2'b11, "R5");
        step(2'b01, "R7");
        step(2'b10, "R7");
        step(2'b01, "R7");
        step(2'b10, "R7");

        // R5 then R7 from state C
        do_reset();
        step(2'b01, "R2");
        step(2'b11, "R5");
        step(2'b10, "R7");
        step(2'b01, "R7");

        // R1 and R4 after recovery
        do_reset();
        step(2'b10, "R1");
        for (int i = 0; i < 40; i++) begin
            step(($urandom_range(0, 1) == 1) ? 2'b10 : 2'b01, "R4");
        end

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule